// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits between a 15-bit-word processor core and its two memories: an erasable RAM of 2048 words and a fixed ROM of up to 36 banks of 1024 words. The core issues a 12-bit address. The mapper turns that address and its own bank registers into one physical address, together with a select for RAM or ROM.

Several banks share the same core addresses. Which physical word is reached depends on three registers held here:
- a 3-bit erasable-bank register,
- a 5-bit fixed-bank register,
- a one-bit super-bank flag, loaded through an I/O channel write.

The core's address space is laid out as follows:

| Core address | Contents |
|---|---|
| 0x000–0x2FF | Erasable banks 0 to 2, always visible |
| 0x300–0x3FF | The erasable bank named by the erasable-bank register |
| 0x400–0x7FF | The fixed bank named by the fixed-bank register, widened by the super flag |
| 0x800–0xFFF | Two fixed "home" banks that are always present |

Bank register writes are registered, so a new mapping applies only from the next cycle. Writes aimed at fixed memory never reach a memory. They raise a drop flag instead. Each memory word is 16 bits wide, with data in the low 15 bits and the top bit normally clear.

Top module: `bank_mapper`

## Requirements
- R1: After reset all three bank registers are zero. A read at 0x300 gives RAM address 0x000, and a read at 0x400 gives ROM address 0x0000.
- R2: A core address from 0x000 to 0x2FF drives `ram_sel` and a physical address equal to the core address, whatever the bank registers hold.
- R3: A core address from 0x300 to 0x3FF drives `ram_sel` and the RAM address eb*256 + addr[7:0]. One RAM word can therefore be reached through two core addresses.
- R4: A read from 0x400 to 0x7FF, with the super flag clear, drives `rom_sel` and the ROM address fb*1024 + addr[9:0].
- R5: With the super flag set and fb in 24..31, the fixed window reaches bank fb+8, so the address is (fb+8)*1024 + addr[9:0].
- R6: With the super flag set and fb below 24, the flag is ignored and the mapping is as in R4.
- R7: When the resulting fixed bank is 36 or higher, neither `ram_sel` nor `rom_sel` is raised.
- R8: A read from 0x800 to 0xBFF reaches ROM bank 2, and a read from 0xC00 to 0xFFF reaches ROM bank 3. Both use offset addr[9:0], independent of fb and the super flag.
- R9: A bank register write never changes the mapping of an access in the same cycle. From the following cycle the new value applies.
- R10: A write (`cpu_wr`=1) to any address at 0x400 or above raises `wr_drop` and keeps `rom_sel` and `ram_we` low. A write to erasable space raises `ram_we` and `ram_sel`.
- R11: With `cpu_en` low, `ram_sel`, `rom_sel`, `ram_we` and `wr_drop` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_en | input | 1 | Access valid this cycle |
| cpu_wr | input | 1 | Access is a write |
| cpu_addr | input | 12 | Core address |
| eb_we | input | 1 | Load the erasable-bank register |
| eb_wdata | input | 3 | New erasable bank |
| fb_we | input | 1 | Load the fixed-bank register |
| fb_wdata | input | 5 | New fixed bank |
| chan_we | input | 1 | I/O channel write that loads the super flag |
| chan_super | input | 1 | New super flag value |
| ram_sel | output | 1 | RAM access |
| ram_we | output | 1 | RAM write strobe |
| rom_sel | output | 1 | ROM read |
| wr_drop | output | 1 | Write to fixed memory discarded |
| phys_addr | output | 16 | Physical RAM or ROM address |

## Verification
The assertions check the following on every cycle:
- the select and drop outputs stay mutually exclusive and silent when idle;
- a dropped write never strobes RAM;
- the home banks and the unswitched erasable range always map as fixed;
- the switched erasable window holds still when no bank write preceded it.

The bank arithmetic needs the bench's scenarios. These cover the super-flag window at its 23/24 boundary, banks past the 36th, old-versus-new mapping in the cycle of a register write, and aliasing of one RAM word through two core addresses in a behavioural memory model.

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int EB_W       = 3,
  parameter int FB_W       = 5,
  parameter int FIX_BANKS  = 36,
  parameter int SUPER_FROM = 24,
  parameter int SUPER_ADD  = 8,
  parameter int HOME_LO    = 2,
  parameter int HOME_HI    = 3,
  parameter int PHYS_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_en,
  input  logic              cpu_wr,
  input  logic [11:0]       cpu_addr,
  input  logic              eb_we,
  input  logic [EB_W-1:0]   eb_wdata,
  input  logic              fb_we,
  input  logic [FB_W-1:0]   fb_wdata,
  input  logic              chan_we,
  input  logic              chan_super,
  output logic              ram_sel,
  output logic              ram_we,
  output logic              rom_sel,
  output logic              wr_drop,
  output logic [PHYS_W-1:0] phys_addr
);
  localparam int OFF_W  = 10;
  localparam int BANK_W = PHYS_W - OFF_W;
  localparam int RAM_AW = EB_W + 8;

  logic [EB_W-1:0]   eb_q;
  logic [FB_W-1:0]   fb_q;
  logic              super_q;
  logic [BANK_W-1:0] fb_bank, rom_bank;
  logic [RAM_AW-1:0] ram_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eb_q    <= '0;
      fb_q    <= '0;
      super_q <= 1'b0;
    end else begin
      if (eb_we)   eb_q    <= eb_wdata;
      if (fb_we)   fb_q    <= fb_wdata;
      if (chan_we) super_q <= chan_super;
    end
  end

  wire in_fixed = cpu_addr[11] | cpu_addr[10];
  wire in_home  = cpu_addr[11];
  wire in_swe   = (cpu_addr[11:8] == 4'd3);

  always_comb begin
    fb_bank = BANK_W'(fb_q);
    if (super_q && (32'(fb_q) >= SUPER_FROM))
      fb_bank = BANK_W'(fb_q) + BANK_W'(SUPER_ADD);
    if (in_home)
      rom_bank = cpu_addr[10] ? BANK_W'(HOME_HI) : BANK_W'(HOME_LO);
    else
      rom_bank = fb_bank;
  end

  wire rom_ok = (32'(rom_bank) < FIX_BANKS);

  assign ram_addr  = in_swe ? {eb_q, cpu_addr[7:0]} : RAM_AW'(cpu_addr[9:0]);
  assign phys_addr = in_fixed ? {rom_bank, cpu_addr[9:0]} : PHYS_W'(ram_addr);

  assign ram_sel = cpu_en & ~in_fixed;
  assign ram_we  = cpu_en & ~in_fixed & cpu_wr;
  assign rom_sel = cpu_en & in_fixed & ~cpu_wr & rom_ok;
  assign wr_drop = cpu_en & in_fixed & cpu_wr;
endmodule

module bank_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_en,
  input logic        cpu_wr,
  input logic [11:0] cpu_addr,
  input logic        eb_we,
  input logic        ram_sel,
  input logic        ram_we,
  input logic        rom_sel,
  input logic        wr_drop,
  input logic [15:0] phys_addr
);
  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, rom_sel, wr_drop})); // R10
  AST_DROP_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> !ram_we && !rom_sel); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en |-> !ram_sel && !rom_sel && !ram_we && !wr_drop); // R11
  AST_UNSWITCHED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en && cpu_addr < 12'h300 |-> ram_sel && phys_addr == {4'd0, cpu_addr}); // R2
  AST_HOME_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en && !cpu_wr && cpu_addr[11] |->
      rom_sel && phys_addr[15:10] == (cpu_addr[10] ? 6'd3 : 6'd2)); // R8
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en && $past(cpu_en) && cpu_addr == $past(cpu_addr) &&
    cpu_addr[11:8] == 4'd3 && !$past(eb_we) |-> $stable(phys_addr)); // R9
endmodule

bind bank_mapper bank_mapper_chk u_chk (.*);

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_en = 1'b0, cpu_wr = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic        eb_we = 1'b0, fb_we = 1'b0, chan_we = 1'b0, chan_super = 1'b0;
  logic [2:0]  eb_wdata = '0;
  logic [4:0]  fb_wdata = '0;
  logic        ram_sel, ram_we, rom_sel, wr_drop;
  logic [15:0] phys_addr;
  logic [15:0] wdata = '0;
  logic [15:0] ram_model [2048];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bank_mapper u_bank_mapper (.*);

  always @(posedge clk) if (ram_we) ram_model[phys_addr[10:0]] <= wdata;

  // {eb[3], fb[5], super[1], addr[12], sel[2] (0 none,1 RAM,2 ROM), phys[16]}
  localparam logic [38:0] VEC [13] = '{
    {3'd0, 5'd0,  1'b0, 12'h000, 2'd1, 16'h0000}, // R2
    {3'd0, 5'd0,  1'b0, 12'h2FF, 2'd1, 16'h02FF}, // R2
    {3'd5, 5'd0,  1'b0, 12'h312, 2'd1, 16'h0512}, // R3
    {3'd7, 5'd0,  1'b0, 12'h3FF, 2'd1, 16'h07FF}, // R3
    {3'd0, 5'd9,  1'b0, 12'h4AB, 2'd2, 16'h24AB}, // R4
    {3'd0, 5'd23, 1'b1, 12'h400, 2'd2, 16'h5C00}, // R6
    {3'd0, 5'd24, 1'b1, 12'h401, 2'd2, 16'h8001}, // R5
    {3'd0, 5'd27, 1'b1, 12'h7FF, 2'd2, 16'h8FFF}, // R5
    {3'd0, 5'd28, 1'b1, 12'h400, 2'd0, 16'h0000}, // R7
    {3'd0, 5'd31, 1'b0, 12'h500, 2'd2, 16'h7D00}, // R4
    {3'd0, 5'd31, 1'b1, 12'h900, 2'd2, 16'h0900}, // R8
    {3'd6, 5'd17, 1'b1, 12'hC05, 2'd2, 16'h0C05}, // R8
    {3'd3, 5'd2,  1'b0, 12'h2A0, 2'd1, 16'h02A0}  // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_banks(input logic [2:0] e, input logic [4:0] f, input logic s);
    @(negedge clk);
    cpu_en = 1'b0;
    eb_we = 1'b1; eb_wdata = e;
    fb_we = 1'b1; fb_wdata = f;
    chan_we = 1'b1; chan_super = s;
    @(negedge clk);
    eb_we = 1'b0; fb_we = 1'b0; chan_we = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cpu_en = 1'b1; cpu_addr = 12'h300; #1;
    check("R1 ram addr", {15'd0, ram_sel, phys_addr}, {15'd0, 1'b1, 16'h0000});
    cpu_addr = 12'h400; #1;
    check("R1 rom addr", {15'd0, rom_sel, phys_addr}, {15'd0, 1'b1, 16'h0000});

    for (int i = 0; i < 13; i++) begin
      set_banks(VEC[i][38:36], VEC[i][35:31], VEC[i][30]);
      cpu_en = 1'b1; cpu_wr = 1'b0; cpu_addr = VEC[i][29:18]; #1;
      check($sformatf("R2-R8 vec%0d sel", i), {30'd0, rom_sel, ram_sel}, {30'd0, VEC[i][17:16]});
      if (VEC[i][17:16] != 2'd0)
        check($sformatf("R2-R8 vec%0d addr", i), {16'd0, phys_addr}, {16'd0, VEC[i][15:0]});
    end

    // R9: same-cycle erasable-bank write sees old mapping
    set_banks(3'd1, 5'd2, 1'b0);
    cpu_en = 1'b1; cpu_addr = 12'h310; eb_we = 1'b1; eb_wdata = 3'd4; #1;
    check("R9 eb old", {16'd0, phys_addr}, 32'h0110);
    @(negedge clk); eb_we = 1'b0; #1;
    check("R9 eb new", {16'd0, phys_addr}, 32'h0410);
    cpu_addr = 12'h400; fb_we = 1'b1; fb_wdata = 5'd6; #1;
    check("R9 fb old", {16'd0, phys_addr}, 32'h0800);
    @(negedge clk); fb_we = 1'b0; #1;
    check("R9 fb new", {16'd0, phys_addr}, 32'h1800);

    // R10: write to fixed space dropped
    cpu_wr = 1'b1; cpu_addr = 12'h500; #1;
    check("R10 drop", {29'd0, wr_drop, rom_sel, ram_we}, 32'b100);
    cpu_addr = 12'hC00; #1;
    check("R10 drop home", {29'd0, wr_drop, rom_sel, ram_we}, 32'b100);

    // R3/R10: write through switched window, read back through fixed alias
    set_banks(3'd2, 5'd0, 1'b0);
    cpu_en = 1'b1; cpu_wr = 1'b1; cpu_addr = 12'h305; wdata = 16'h2ABC; #1;
    check("R10 ram write", {29'd0, wr_drop, ram_sel, ram_we}, 32'b011);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = 12'h205; #1;
    check("R3 alias read", {16'd0, ram_model[phys_addr[10:0]]}, 32'h2ABC);

    // R6 super flag ignored below 24
    set_banks(3'd0, 5'd20, 1'b1);
    cpu_en = 1'b1; cpu_addr = 12'h401; #1;
    check("R6 ignored", {16'd0, phys_addr}, 32'h5001);

    // R11: idle
    cpu_en = 1'b0; cpu_wr = 1'b1; cpu_addr = 12'h123; #1;
    check("R11 idle", {28'd0, ram_sel, rom_sel, ram_we, wr_drop}, 32'd0);
    cpu_addr = 12'h600; #1;
    check("R11 idle fixed", {28'd0, ram_sel, rom_sel, ram_we, wr_drop}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule